// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt sources into two processor-facing request lines, one for critical and one for ordinary interrupts. Each source is brought into the clock domain through a two-flop synchroniser. It can then be set on its own to be active-high or active-low, and to be sensed as a level or as an edge. Detected activity is held in a status register. The status register is ANDed with an enable register and steered by a critical-select register onto one of the two outputs.

Alongside the request lines, the block keeps a vector register. It holds a software-chosen base address plus 512 times the rank of the winning pending source, so a handler can jump straight to a per-source slot. Software chooses which end of the source range wins. It can also force status bits for test or for software-raised interrupts, and clears them by writing ones. All access goes through a flat 32-bit register port with word offsets.

Top module: `irqv_top`

## Requirements
- R1: After reset every register reads zero, both request outputs are low, and the vector reads zero, provided every input stays at its inactive (high) level.
- R2: Register word offsets (byte address): status 0x00, status-set 0x04, enable 0x08, critical-select 0x0C, polarity 0x10, trigger 0x14, masked status 0x18 (read-only), vector 0x1C (read-only), vector config 0x20. Enable, critical-select, polarity, trigger and vector config read back what was written. A read returns data one clock after the address is presented. Unmapped offsets read zero.
- R3: Source N corresponds to bit (31−N) of every register and to `irq_in[31−N]`, so source 0 is the MSB.
- R4: A polarity bit of 0 makes the source active when its input is low. A polarity bit of 1 makes it active when its input is high.
- R5: With its trigger bit 0 (level), a source's status bit is set on every cycle its synchronised input is active. Writing a 1 to clear it has no lasting effect while the input stays active. The bit stays set after the input goes inactive until it is cleared.
- R6: With its trigger bit 1 (edge), a source's status bit is set only on a transition into the active level. Once cleared, it stays clear while the input is held active.
- R7: A write to status-set forces every bit that is 1 in the written data to 1 in status, and leaves the other bits alone.
- R8: A write to status clears each bit written as 1, and leaves bits written as 0 unchanged.
- R9: Masked status reads status AND enable.
- R10: `irq_crit` is high when some source is enabled, pending and marked critical. `irq_norm` is high when some source is enabled, pending and not marked critical. Both are registered.
- R11: With vector-config bit 0 set to 1, the lowest-numbered enabled pending source N wins, and the vector equals (vector config with its two LSBs cleared) + N*512.
- R12: With vector-config bit 0 set to 0, the highest-numbered enabled pending source N wins, and the vector equals that base + (31−N)*512.
- R13: With no enabled pending source, the vector equals the base alone and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous source inputs, source N on bit 31−N |
| addr | input | 6 | Byte address of the register port |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| irq_crit | output | 1 | Critical interrupt request |
| irq_norm | output | 1 | Non-critical interrupt request |

## Verification
The hardest condition to reach is the difference between a level source and an edge source while the input is still held active. In that window a clear must be undone at once for a level source, but must stick for an edge source. The bench holds a source input low across a clear write, reads status back while the input is still asserted, and only then releases it. The polarity flip is also delicate, because changing polarity on a live input can itself look like activity. The stimulus therefore flips polarity only after the input sits at the level that becomes inactive, clears status, and then drives the new active level.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  // word index = byte address [5:2]
  typedef enum logic [3:0] {
    RG_STAT  = 4'd0,
    RG_SETS  = 4'd1,
    RG_ENAB  = 4'd2,
    RG_CRIT  = 4'd3,
    RG_POL   = 4'd4,
    RG_TRIG  = 4'd5,
    RG_MSTAT = 4'd6,
    RG_VEC   = 4'd7,
    RG_VCFG  = 4'd8
  } reg_idx_t;
endpackage

// File: rtl/irqv_sense.sv
module irqv_sense #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  output logic [N-1:0] hit
);
  logic [N-1:0] s1_q, s2_q, act_q;
  logic [N-1:0] act;

  // Sync flops reset to the idle level of active-low inputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= '1;
      s2_q  <= '1;
      act_q <= '0;
    end else begin
      s1_q  <= raw;
      s2_q  <= s1_q;
      act_q <= act;
    end
  end

  assign act = ~(s2_q ^ pol);

  for (genvar g = 0; g < N; g++) begin : g_src
    assign hit[g] = trig[g] ? (act[g] & ~act_q[g]) : act[g];
  end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int N         = 32,
  parameter int DW        = 32,
  parameter int STRIDE_LG = 9
) (
  input  logic [N-1:0]  pend,
  input  logic          low_first,
  input  logic [DW-1:0] base,
  output logic [DW-1:0] vec
);
  localparam int OW = $clog2(N);
  logic [OW-1:0] rank;
  logic          found;

  // rank i walks from the winning end of the range
  always_comb begin
    rank  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && pend[low_first ? (N-1-i) : i]) begin
        found = 1'b1;
        rank  = OW'(i);
      end
    end
  end

  assign vec = base + (DW'(rank) << STRIDE_LG);
endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
  parameter int N         = 32,
  parameter int DW        = 32,
  parameter int AW        = 6,
  parameter int STRIDE_LG = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq_crit,
  output logic          irq_norm
);
  import irqv_pkg::*;

  logic [N-1:0]  stat_q, en_q, crit_q, pol_q, trig_q;
  logic [DW-1:0] vcfg_q, vec_q;
  logic [N-1:0]  hit, masked, clr_m, set_m;
  logic [DW-1:0] base, vec_d;
  logic [3:0]    widx;

  assign widx   = addr[5:2];
  assign masked = stat_q & en_q;
  assign base   = {vcfg_q[DW-1:2], 2'b00};
  assign clr_m  = (wr_en && widx == RG_STAT) ? wr_data[N-1:0] : '0;
  assign set_m  = (wr_en && widx == RG_SETS) ? wr_data[N-1:0] : '0;

  irqv_sense #(.N(N)) u_sense (
    .clk(clk), .rst(rst), .raw(irq_in), .pol(pol_q), .trig(trig_q), .hit(hit)
  );

  irqv_prio #(.N(N), .DW(DW), .STRIDE_LG(STRIDE_LG)) u_prio (
    .pend(masked), .low_first(vcfg_q[0]), .base(base), .vec(vec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      vcfg_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_m) | set_m | hit;
      if (wr_en) begin
        case (widx)
          RG_ENAB: en_q   <= wr_data[N-1:0];
          RG_CRIT: crit_q <= wr_data[N-1:0];
          RG_POL:  pol_q  <= wr_data[N-1:0];
          RG_TRIG: trig_q <= wr_data[N-1:0];
          RG_VCFG: vcfg_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q    <= '0;
      irq_crit <= 1'b0;
      irq_norm <= 1'b0;
      rd_data  <= '0;
    end else begin
      vec_q    <= vec_d;
      irq_crit <= |(masked & crit_q);
      irq_norm <= |(masked & ~crit_q);
      case (widx)
        RG_STAT:  rd_data <= DW'(stat_q);
        RG_ENAB:  rd_data <= DW'(en_q);
        RG_CRIT:  rd_data <= DW'(crit_q);
        RG_POL:   rd_data <= DW'(pol_q);
        RG_TRIG:  rd_data <= DW'(trig_q);
        RG_MSTAT: rd_data <= DW'(masked);
        RG_VEC:   rd_data <= vec_q;
        RG_VCFG:  rd_data <= vcfg_q;
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int N  = 32,
  parameter int DW = 32,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wr_data,
  input logic [N-1:0]  stat_q,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  crit_q,
  input logic [DW-1:0] vcfg_q,
  input logic [DW-1:0] vec_q,
  input logic          irq_crit,
  input logic          irq_norm
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_crit && !irq_norm && vec_q == '0));

  // R7
  set_forces_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[5:2] == 4'd1) |=> ((stat_q & $past(wr_data[N-1:0])) == $past(wr_data[N-1:0])));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr[5:2] == 4'd0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R10
  crit_route_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_crit == $past(|(stat_q & en_q & crit_q))));

  // R10
  norm_route_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_norm == $past(|(stat_q & en_q & ~crit_q))));

  // R13
  idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & en_q) == '0) |=> (vec_q == {$past(vcfg_q[DW-1:2]), 2'b00}));
endmodule

bind irqv_top irqv_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .stat_q(stat_q), .en_q(en_q), .crit_q(crit_q), .vcfg_q(vcfg_q),
  .vec_q(vec_q), .irq_crit(irq_crit), .irq_norm(irq_norm)
);

// File: tb/irqv_top_tb.sv
module irqv_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '1;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_crit, irq_norm;
  int n_chk = 0, n_bad = 0, cyc = 0;

  localparam logic [5:0] A_STAT = 6'h00, A_SETS = 6'h04, A_ENAB = 6'h08, A_CRIT = 6'h0C,
    A_POL = 6'h10, A_TRIG = 6'h14, A_MST = 6'h18, A_VEC = 6'h1C, A_VCFG = 6'h20;

  irqv_top u_dut (.clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_crit(irq_crit), .irq_norm(irq_norm));

  always #4 clk = ~clk;

  function automatic logic [31:0] m(int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired act=%0d exp<%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    idle(3);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk); irq_in = v;
    idle(6);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), d);
      chk("R1", d, 32'h0);
    end
    chk("R1", {30'd0, irq_crit, irq_norm}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_CRIT, 32'hA5A5_0F0F); rd(A_CRIT, d); chk("R2", d, 32'hA5A5_0F0F);
    wr(A_TRIG, 32'h1234_5678); rd(A_TRIG, d); chk("R2", d, 32'h1234_5678);
    wr(A_VCFG, 32'hDEAD_BEEF); rd(A_VCFG, d); chk("R2", d, 32'hDEAD_BEEF);
    rd(A_VEC, d); chk("R13", d, 32'hDEAD_BEEC);
    wr(A_ENAB, 32'h0F0F_F0F0); rd(A_ENAB, d); chk("R2", d, 32'h0F0F_F0F0);
    wr(A_MST, 32'hFFFF_FFFF); rd(A_MST, d); chk("R2", d, 32'h0);
    wr(A_CRIT, 0); wr(A_TRIG, 0); wr(A_VCFG, 0); wr(A_ENAB, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    drive(irq_in & ~m(5));
    rd(A_STAT, d); chk("R3", d, m(5));
    rd(A_MST, d); chk("R9", d, 32'h0);
    wr(A_STAT, m(5)); rd(A_STAT, d); chk("R5", d, m(5));
    drive(irq_in | m(5));
    rd(A_STAT, d); chk("R5", d, m(5));
    wr(A_STAT, m(5)); rd(A_STAT, d); chk("R5", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(A_TRIG, m(7));
    drive(irq_in & ~m(7));
    rd(A_STAT, d); chk("R6", d, m(7));
    wr(A_STAT, m(7)); idle(4);
    rd(A_STAT, d); chk("R6", d, 32'h0);
    drive(irq_in | m(7));
    rd(A_STAT, d); chk("R6", d, 32'h0);
    wr(A_TRIG, 0);
  endtask

  task automatic t_pol();
    logic [31:0] d;
    drive(irq_in & ~m(9));
    wr(A_POL, m(9));
    wr(A_STAT, m(9)); idle(4);
    rd(A_STAT, d); chk("R4", d, 32'h0);
    drive(irq_in | m(9));
    rd(A_STAT, d); chk("R4", d, m(9));
    drive(irq_in & ~m(9));
    wr(A_STAT, m(9)); idle(4);
    rd(A_STAT, d); chk("R4", d, 32'h0);
    rd(A_POL, d); chk("R2", d, m(9));
  endtask

  task automatic t_set();
    logic [31:0] d;
    wr(A_SETS, m(0) | m(15) | m(31));
    rd(A_STAT, d); chk("R7", d, m(0) | m(15) | m(31));
    wr(A_STAT, m(15) | m(4));
    rd(A_STAT, d); chk("R8", d, m(0) | m(31));
    wr(A_STAT, '1); rd(A_STAT, d); chk("R8", d, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(A_SETS, m(2) | m(20));
    chk("R13", {30'd0, irq_crit, irq_norm}, 32'h0);
    wr(A_ENAB, m(2));
    rd(A_MST, d); chk("R9", d, m(2));
    chk("R10", {30'd0, irq_crit, irq_norm}, 32'h1);
    wr(A_CRIT, m(2));
    chk("R10", {30'd0, irq_crit, irq_norm}, 32'h2);
    wr(A_ENAB, m(2) | m(20));
    chk("R10", {30'd0, irq_crit, irq_norm}, 32'h3);
    wr(A_STAT, '1); wr(A_ENAB, 0); wr(A_CRIT, 0);
    chk("R13", {30'd0, irq_crit, irq_norm}, 32'h0);
  endtask

  task automatic t_vec();
    logic [31:0] d;
    wr(A_ENAB, '1);
    wr(A_VCFG, 32'h0001_0003);
    rd(A_VEC, d); chk("R13", d, 32'h0001_0000);
    wr(A_SETS, m(3) | m(17));
    rd(A_VEC, d); chk("R11", d, 32'h0001_0000 + 3 * 512);
    wr(A_VCFG, 32'h0001_0002);
    rd(A_VEC, d); chk("R12", d, 32'h0001_0000 + 14 * 512);
    wr(A_STAT, '1); wr(A_SETS, m(31));
    rd(A_VEC, d); chk("R12", d, 32'h0001_0000);
    wr(A_VCFG, 32'h0001_0001);
    rd(A_VEC, d); chk("R11", d, 32'h0001_0000 + 31 * 512);
    wr(A_STAT, '1); wr(A_SETS, m(0));
    rd(A_VEC, d); chk("R11", d, 32'h0001_0000);
    wr(A_VCFG, 32'h0001_0000);
    rd(A_VEC, d); chk("R12", d, 32'h0001_0000 + 31 * 512);
    wr(A_STAT, '1);
    rd(A_VEC, d); chk("R13", d, 32'h0001_0000);
    wr(A_ENAB, 0);
  endtask

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    idle(4);
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_pol();
    t_set();
    t_route();
    t_vec();
    finish_run();
  end
endmodule